// File: doc/BRIEF.md
# Up/Down Counter-Timer with Falling-Edge Capture

This block is a 16-bit counter-timer that moves by one on each cycle in which its count strobe is high. Software picks the direction. Clock division and clock-source choice happen outside the block, which sees only the single strobe `tick`. The counter advances only while both the run bit and the capture-mode select bit are set.

A separate external pin, `cap_pin`, is brought into the clock domain through a two-flop synchronizer. When capture is enabled, each high-to-low change on that pin copies the live count into a 16-bit capture register and raises a sticky capture flag. A rollover in either direction raises a second sticky flag, the wrap flag. The registered interrupt output combines the two flags, each gated by its own enable bit.

Software reaches every field through a byte-wide register port. Writes are single-cycle and reads are combinational.

Top module: `cap_timer`

## Requirements
- R1: After reset, every register reads 0x00 and `irq` is 0: control, flags, both counter bytes and both capture bytes.
- R2: The counter changes only on a clock edge where `tick` is 1, run (control bit 1) is 1 and capture-mode select (control bit 0) is 1. With the direction bit (control bit 3) at 0, it then increases by exactly one.
- R3: When counting up, a step from 0xFFFF gives 0x0000 and sets the wrap flag (flag register bit 0).
- R4: With the direction bit at 1, each count step decreases the counter by one. A step from 0x0000 gives 0xFFFF and sets the same wrap flag.
- R5: With capture enable (control bit 2) at 1, a falling edge on `cap_pin` does two things on the third rising clock edge after the pin changes: it loads the capture register with the counter value from before that edge, and it sets the capture flag (flag register bit 1).
- R6: With capture enable at 0, transitions on `cap_pin` leave both the capture register and the capture flag unchanged.
- R7: A rising edge on `cap_pin` never captures. A pin held low produces exactly one capture.
- R8: Both flags are sticky. A flag clears only when software writes 0 to its bit at address 1, and writing 1 to a flag bit has no effect. If a hardware set and a software clear fall on the same edge, the set wins.
- R9: `irq` is registered. One cycle after the flags and enables change, it equals (capture flag AND control bit 4) OR (wrap flag AND control bit 5).
- R10: A software write to a counter byte that coincides with a count step takes priority. The written byte takes the data, the other byte keeps its value, no step is applied and no wrap flag is set.
- R11: The register map is: address 0 control (bits 5..0 as named above), 1 flags, 2 counter low byte, 3 counter high byte, 4 capture low byte, 5 capture high byte. All of these read back the values written. A write to the capture bytes is overridden by a capture on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Count strobe, one step per high cycle |
| cap_pin | input | 1 | Asynchronous capture pin, falling edge triggers |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data for `addr` |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench drives the counter through both wrap points. A wrong boundary compare would either miss the flag or raise it one step early. It also lines up a software counter write with a live count strobe. A design that lets the count win there would show the written byte plus one, or a spurious wrap. Captures are exercised while the counter is stopped and while it runs: a design that samples after the count, or that fires on the rising edge, shows a value off by one or an extra flag. The same-cycle flag clear against a capture exposes a design that loses the hardware event.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;

  // register addresses; counter and capture bytes follow from CNT_BASE
  localparam int unsigned CTRL_ADDR = 0;
  localparam int unsigned FLAG_ADDR = 1;
  localparam int unsigned CNT_BASE  = 2;

  localparam int unsigned CTRL_W = 6;

  // packed control word, bit 0 at the bottom (cap_sel)
  typedef struct packed {
    logic ovf_ie;   // bit 5
    logic cap_ie;   // bit 4
    logic down;     // bit 3
    logic cap_en;   // bit 2
    logic run;      // bit 1
    logic cap_sel;  // bit 0
  } ctrl_t;

endpackage

// File: rtl/cap_timer_rst_sync.sv
module cap_timer_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];

endmodule

// File: rtl/cap_timer_edge.sv
module cap_timer_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall_o
);

  // SYNC_STAGES synchronizer flops plus one history flop
  logic [SYNC_STAGES:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[SYNC_STAGES-1:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // older synchronized sample high, newer low: one pulse per falling edge
  assign fall_o = sh_q[SYNC_STAGES] & ~sh_q[SYNC_STAGES-1];

endmodule

// File: rtl/cap_timer_count.sv
module cap_timer_count #(
  parameter int unsigned CNT_W = 16,
  localparam int unsigned BYTES = CNT_W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BYTES-1:0] byte_we,
  input  logic [7:0]       wr_byte,
  input  logic             step,
  input  logic             down,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sw_wr;
  logic             at_edge;

  assign sw_wr   = |byte_we;
  assign at_edge = down ? (cnt_q == '0) : (&cnt_q);

  always_comb begin
    cnt_d = cnt_q;
    if (sw_wr) begin
      for (int b = 0; b < int'(BYTES); b++) begin
        if (byte_we[b]) cnt_d[b*8 +: 8] = wr_byte;
      end
    end else if (step) begin
      cnt_d = down ? (cnt_q - CNT_W'(1)) : (cnt_q + CNT_W'(1));
    end
  end

  // a rollover counts only when the step actually applies
  assign wrap_o = step & ~sw_wr & at_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/cap_timer_capreg.sv
module cap_timer_capreg #(
  parameter int unsigned CNT_W = 16,
  localparam int unsigned BYTES = CNT_W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grab,
  input  logic [CNT_W-1:0] live,
  input  logic [BYTES-1:0] byte_we,
  input  logic [7:0]       wr_byte,
  output logic [CNT_W-1:0] cap_o
);

  logic [CNT_W-1:0] cap_q, cap_d;
  logic             cap_ld;

  always_comb begin
    cap_d = cap_q;
    if (grab) begin
      cap_d = live;
    end else begin
      for (int b = 0; b < int'(BYTES); b++) begin
        if (byte_we[b]) cap_d[b*8 +: 8] = wr_byte;
      end
    end
  end

  assign cap_ld = grab | (|byte_we);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap_q <= '0;
    else if (cap_ld) cap_q <= cap_d;
  end

  assign cap_o = cap_q;

endmodule

// File: rtl/cap_timer.sv
module cap_timer
  import cap_timer_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cap_pin,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic              irq
);

  localparam int unsigned BYTES    = CNT_W / 8;
  localparam int unsigned CAP_BASE = CNT_BASE + BYTES;

  logic             rst_n_s;
  ctrl_t            ctrl_q;
  logic             ctrl_we;
  logic             flag_we;
  logic [BYTES-1:0] cnt_we, cap_we;
  logic [CNT_W-1:0] cnt, cap;
  logic             step, wrap, fall, grab;
  logic             ovf_flag_q, ovf_flag_d;
  logic             cap_flag_q, cap_flag_d;
  logic             irq_q, irq_d;

  cap_timer_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_s)
  );

  // address decode
  assign ctrl_we = wr_en && (addr == ADDR_W'(CTRL_ADDR));
  assign flag_we = wr_en && (addr == ADDR_W'(FLAG_ADDR));

  for (genvar b = 0; b < int'(BYTES); b++) begin : g_dec
    assign cnt_we[b] = wr_en && (addr == ADDR_W'(CNT_BASE + b));
    assign cap_we[b] = wr_en && (addr == ADDR_W'(CAP_BASE + b));
  end

  // control register
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
  end

  assign step = tick & ctrl_q.run & ctrl_q.cap_sel;

  cap_timer_count #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .byte_we (cnt_we),
    .wr_byte (wr_data),
    .step    (step),
    .down    (ctrl_q.down),
    .cnt_o   (cnt),
    .wrap_o  (wrap)
  );

  cap_timer_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .pin    (cap_pin),
    .fall_o (fall)
  );

  assign grab = fall & ctrl_q.cap_en;

  cap_timer_capreg #(.CNT_W(CNT_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .grab    (grab),
    .live    (cnt),
    .byte_we (cap_we),
    .wr_byte (wr_data),
    .cap_o   (cap)
  );

  // sticky flags: software clears with 0, hardware set wins
  always_comb begin
    ovf_flag_d = (ovf_flag_q & ~(flag_we & ~wr_data[0])) | wrap;
    cap_flag_d = (cap_flag_q & ~(flag_we & ~wr_data[1])) | grab;
    irq_d      = (cap_flag_q & ctrl_q.cap_ie) | (ovf_flag_q & ctrl_q.ovf_ie);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ovf_flag_q <= 1'b0;
      cap_flag_q <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      ovf_flag_q <= ovf_flag_d;
      cap_flag_q <= cap_flag_d;
      irq_q      <= irq_d;
    end
  end

  assign irq = irq_q;

  // read mux
  always_comb begin
    rd_data = '0;
    if (addr == ADDR_W'(CTRL_ADDR)) rd_data = {{(8-CTRL_W){1'b0}}, ctrl_q};
    if (addr == ADDR_W'(FLAG_ADDR)) rd_data = {6'b0, cap_flag_q, ovf_flag_q};
    for (int b = 0; b < int'(BYTES); b++) begin
      if (addr == ADDR_W'(CNT_BASE + b)) rd_data = cnt[b*8 +: 8];
      if (addr == ADDR_W'(CAP_BASE + b)) rd_data = cap[b*8 +: 8];
    end
  end

endmodule

// File: rtl/cap_timer_chk.sv
module cap_timer_chk #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step,
  input logic              down,
  input logic              cnt_wr,
  input logic              cap_wr,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  cap,
  input logic              fall,
  input logic              cap_en,
  input logic              cap_ie,
  input logic              ovf_ie,
  input logic              ovf_flag,
  input logic              cap_flag,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wr_data,
  input logic              irq
);

  logic clr_cap;
  assign clr_cap = wr_en && (addr == ADDR_W'(1)) && !wr_data[1];

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !cnt_wr) |=> $stable(cnt));

  a_r3_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !down && !cnt_wr && (&cnt)) |=> (cnt == '0 && ovf_flag));

  a_r4_down_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && down && !cnt_wr && cnt == '0) |=> ((&cnt) && ovf_flag));

  a_r5_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && cap_en) |=> (cap == $past(cnt) && cap_flag));

  a_r6_capture_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !cap_wr) |=> $stable(cap));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);

  a_r8_sticky_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_flag && !clr_cap) |=> cap_flag);

  a_r9_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ((cap_flag && cap_ie) || (ovf_flag && ovf_ie)) |=> irq);

  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && !ovf_flag) |=> !ovf_flag);

endmodule

bind cap_timer cap_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_s),
  .step     (step),
  .down     (ctrl_q.down),
  .cnt_wr   (|cnt_we),
  .cap_wr   (|cap_we),
  .cnt      (cnt),
  .cap      (cap),
  .fall     (fall),
  .cap_en   (ctrl_q.cap_en),
  .cap_ie   (ctrl_q.cap_ie),
  .ovf_ie   (ctrl_q.ovf_ie),
  .ovf_flag (ovf_flag_q),
  .cap_flag (cap_flag_q),
  .wr_en    (wr_en),
  .addr     (addr),
  .wr_data  (wr_data),
  .irq      (irq_q)
);

// File: tb/cap_timer_tb.sv
module cap_timer_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       cap_pin = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       irq;

  int    checks = 0;
  int    errors = 0;
  bit    cmp_on = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  cap_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cap_pin(cap_pin),
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq)
  );

  // ---------------- behavioural reference ----------------
  logic [15:0] m_cnt, m_cap;
  logic [5:0]  m_ctrl;
  logic        m_ovf, m_capf, m_irq;
  logic [2:0]  m_pipe;   // [0] newest sample

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_cap = 0; m_ctrl = 0; m_ovf = 0; m_capf = 0; m_irq = 0; m_pipe = 0;
    end else begin
      logic [15:0] o_cnt;
      logic [5:0]  o_ctrl;
      logic        fell, set_ovf, set_cap, o_ovf, o_capf;
      o_cnt = m_cnt; o_ctrl = m_ctrl; o_ovf = m_ovf; o_capf = m_capf;
      fell = m_pipe[2] && !m_pipe[1];
      m_pipe = {m_pipe[1:0], cap_pin};
      set_ovf = 0; set_cap = 0;
      if (wr_en && addr == 3'd2) m_cnt[7:0] = wr_data;
      else if (wr_en && addr == 3'd3) m_cnt[15:8] = wr_data;
      else if (tick && o_ctrl[1] && o_ctrl[0]) begin
        if (o_ctrl[3]) begin
          if (o_cnt == 16'h0000) set_ovf = 1;
          m_cnt = o_cnt - 16'd1;
        end else begin
          if (o_cnt == 16'hFFFF) set_ovf = 1;
          m_cnt = o_cnt + 16'd1;
        end
      end
      if (fell && o_ctrl[2]) begin
        m_cap = o_cnt; set_cap = 1;
      end else if (wr_en && addr == 3'd4) m_cap[7:0] = wr_data;
      else if (wr_en && addr == 3'd5) m_cap[15:8] = wr_data;
      if (wr_en && addr == 3'd1) begin
        if (!wr_data[0]) m_ovf = 0;
        if (!wr_data[1]) m_capf = 0;
      end
      if (set_ovf) m_ovf = 1;
      if (set_cap) m_capf = 1;
      m_irq = (o_capf && o_ctrl[4]) || (o_ovf && o_ctrl[5]);
      if (wr_en && addr == 3'd0) m_ctrl = wr_data[5:0];
    end
  end

  function automatic logic [7:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: m_read = {2'b0, m_ctrl};
      3'd1: m_read = {6'b0, m_capf, m_ovf};
      3'd2: m_read = m_cnt[7:0];
      3'd3: m_read = m_cnt[15:8];
      3'd4: m_read = m_cap[7:0];
      3'd5: m_read = m_cap[15:8];
      default: m_read = 8'h00;
    endcase
  endfunction

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      checks++;
      if (rd_data !== m_read(addr) || irq !== m_irq) begin
        errors++;
        $display("FAIL %s model compare addr %0d: rd=%02h irq=%b expected rd=%02h irq=%b",
                 cur_req, addr, rd_data, irq, m_read(addr), m_irq);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic chk_rd(input logic [2:0] a, input logic [7:0] exp, input string req);
    addr = a; #1;
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s read addr %0d: actual %02h expected %02h", req, a, rd_data, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input string req);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s irq: actual %b expected %b", req, irq, exp);
    end
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(posedge clk);
    #1 tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // ---------------- stimulus ----------------
  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(6);
    cmp_on = 1'b1;

    // R1 reset state
    cur_req = "R1";
    for (int a = 0; a < 6; a++) chk_rd(3'(a), 8'h00, "R1");
    chk_irq(1'b0, "R1");

    // R11 register map read-back
    cur_req = "R11";
    wr(3'd0, 8'h3F); chk_rd(3'd0, 8'h3F, "R11");
    wr(3'd0, 8'h00);
    wr(3'd4, 8'hA5); wr(3'd5, 8'h5A);
    chk_rd(3'd4, 8'hA5, "R11"); chk_rd(3'd5, 8'h5A, "R11");

    // R2 gating and up count
    cur_req = "R2";
    wr(3'd2, 8'h10); wr(3'd3, 8'h00);
    wr(3'd0, 8'h02);               // run only
    ticks(4);
    chk_rd(3'd2, 8'h10, "R2");
    wr(3'd0, 8'h01);               // select only
    ticks(3);
    chk_rd(3'd2, 8'h10, "R2");
    wr(3'd0, 8'h03);
    ticks(4);
    chk_rd(3'd2, 8'h14, "R2"); chk_rd(3'd3, 8'h00, "R2");

    // R3 up wrap
    cur_req = "R3";
    wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
    wr(3'd0, 8'h23);
    ticks(2);
    chk_rd(3'd2, 8'h00, "R3"); chk_rd(3'd3, 8'h00, "R3");
    chk_rd(3'd1, 8'h01, "R3");
    idle(1);
    chk_irq(1'b1, "R9");

    // R8 sticky, write 1 no effect, write 0 clears
    cur_req = "R8";
    wr(3'd1, 8'h01); chk_rd(3'd1, 8'h01, "R8");
    wr(3'd1, 8'h02); chk_rd(3'd1, 8'h00, "R8");
    idle(1);
    chk_irq(1'b0, "R9");

    // R4 down count and underflow
    cur_req = "R4";
    wr(3'd0, 8'h0B);
    wr(3'd2, 8'h01); wr(3'd3, 8'h00);
    ticks(2);
    chk_rd(3'd2, 8'hFF, "R4"); chk_rd(3'd3, 8'hFF, "R4");
    chk_rd(3'd1, 8'h01, "R4");
    ticks(1);
    chk_rd(3'd2, 8'hFE, "R4");
    wr(3'd1, 8'h00);

    // R10 software write beats count
    cur_req = "R10";
    wr(3'd0, 8'h03);
    tick = 1'b1;
    wr(3'd2, 8'h50);
    tick = 1'b0;
    chk_rd(3'd2, 8'h50, "R10"); chk_rd(3'd3, 8'hFF, "R10");
    chk_rd(3'd1, 8'h00, "R10");
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    tick = 1'b1;
    wr(3'd3, 8'hFF);               // at 0xFFFF: write wins, no wrap
    tick = 1'b0;
    chk_rd(3'd2, 8'hFF, "R10"); chk_rd(3'd1, 8'h00, "R10");
    wr(3'd2, 8'h50);

    // R5 capture with the counter stopped
    cur_req = "R5";
    wr(3'd0, 8'h17);
    cap_pin = 1'b0;
    idle(2);
    chk_rd(3'd1, 8'h00, "R5");     // two edges in: not yet
    idle(1);
    chk_rd(3'd1, 8'h02, "R5");
    chk_rd(3'd4, 8'h50, "R5"); chk_rd(3'd5, 8'hFF, "R5");
    idle(1);
    chk_irq(1'b1, "R9");

    // R7 held low and rising edge give no more captures
    cur_req = "R7";
    wr(3'd1, 8'h00);
    idle(5);
    chk_rd(3'd1, 8'h00, "R7");
    cap_pin = 1'b1;
    idle(5);
    chk_rd(3'd1, 8'h00, "R7");

    // R5 capture while counting, value checked against the reference
    cur_req = "R5";
    tick = 1'b1;
    idle(3);
    cap_pin = 1'b0;
    idle(6);
    tick = 1'b0;
    idle(1);
    chk_rd(3'd4, m_cap[7:0], "R5");
    chk_rd(3'd1, 8'h02, "R5");
    wr(3'd1, 8'h00);
    cap_pin = 1'b1;
    idle(4);

    // R6 capture disabled
    cur_req = "R6";
    wr(3'd0, 8'h13);
    wr(3'd2, 8'h77);
    cap_pin = 1'b0; idle(5);
    cap_pin = 1'b1; idle(5);
    cap_pin = 1'b0; idle(5);
    chk_rd(3'd1, 8'h00, "R6");
    chk_rd(3'd4, m_cap[7:0], "R6");
    checks++;
    if (m_cap[7:0] == 8'h77) begin
      errors++;
      $display("FAIL R6 reference: actual %02h expected not 77", m_cap[7:0]);
    end
    cap_pin = 1'b1; idle(4);

    // R8 hardware set beats same-cycle clear
    cur_req = "R8";
    wr(3'd0, 8'h07);
    cap_pin = 1'b0;
    @(posedge clk);
    @(posedge clk); #1;
    wr(3'd1, 8'h00);               // lands on the capture edge
    chk_rd(3'd1, 8'h02, "R8");

    // R9 enables gate the interrupt
    cur_req = "R9";
    idle(2);
    chk_irq(1'b0, "R9");
    wr(3'd0, 8'h17);
    idle(1);
    chk_irq(1'b1, "R9");
    wr(3'd1, 8'h00);
    idle(1);
    chk_irq(1'b0, "R9");
    cap_pin = 1'b1;
    idle(4);

    finish_run();
  end

endmodule